// File: doc/BRIEF.md
# Paged LCD Display RAM Controller

This block keeps the dot image of a 132-column graphic LCD panel. The host side works through a page pointer and a column pointer. A page selects a band of eight common rows. A host byte lands vertically in that band, at the selected column: bit 0 goes to the top row of the band and bit 7 to the bottom row. After every host read or write the column pointer moves one step to the right. It stops at the last column and never wraps into the next page. Besides the eight full pages there is a ninth page, one row high, that drives the indicator row. Only bit 0 of a byte written to that page is kept.

The display scan logic has its own read port. It names one common row and, one cycle later, receives that row's segment bits. A registered direction input can reverse the column-to-segment order, so that a panel can be wired either way round. Host accesses and scan reads never hold each other up. When both touch the same location in the same cycle, the scan sees the data from before the write.

Top module: `lcd_dram_ctrl`

## Requirements
- R1: After reset, the page and column pointers are 0, `host_rdata` is 0 and `scan_seg` is 0. The first byte written without setting any pointer lands on page 0, column 0.
- R2: A byte written at page p (0..7), column c stores bit i in common row 8p+i. The scan row 8p+i then shows that bit on segment c (direction 0), and a host read at page p, column c returns the byte.
- R3: Each host read or write advances the column pointer by one, unless `set_col` is given in the same cycle.
- R4: The column pointer stops at 131. Further accesses keep reading or writing column 131.
- R5: The page pointer changes only through `set_page`. Running past column 131 never moves to another page.
- R6: A `set_col` value above 131 sets the column pointer to 131.
- R7: Page 8 is the one-row indicator page (common row 64). A write there stores only bit 0. A read there returns bits 7..1 as zero.
- R8: A write to page code 9..15 changes no stored data, and a read there returns 0.
- R9: `host_rdata` takes the addressed byte at the clock edge that samples `host_rd`, and it holds its value when `host_rd` is low.
- R10: With the direction bit at 1, segment s shows column 131-s. The direction bit is sampled together with the scan row.
- R11: `scan_seg` shows the row sampled one edge earlier. If a host write to that row lands on the same edge, the scan shows the data from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_page | input | 1 | Load the page pointer from `page_in` |
| page_in | input | 4 | New page code (0..7 data, 8 indicator, 9..15 void) |
| set_col | input | 1 | Load the column pointer from `col_in` (clamped) |
| col_in | input | 8 | New column address |
| host_wr | input | 1 | Write `host_wdata` at the current page and column |
| host_rd | input | 1 | Read the byte at the current page and column |
| host_wdata | input | 8 | Byte to write, bit 0 = top row of the page |
| host_rdata | output | 8 | Byte read, valid one edge after `host_rd` |
| scan_row | input | 7 | Common row for the scan side (0..64) |
| seg_reverse | input | 1 | 1 = segment s shows column 131-s |
| scan_seg | output | 132 | Segment bits of the sampled row |

## Verification
A wrong column pointer shows at the next host read: the byte comes from the wrong column, or a byte from a run of writes is missing, and the saturation tests read column 131 twice to catch a wrap. A pointer that carries into the next page shows when the untouched neighbour page is read back and no longer holds its known value. Errors in row mapping, the indicator page or mirroring show one cycle after a scan request, as a segment bit at the wrong position. A write that leaks into a void page code shows when the page it would alias is read back.

// File: rtl/lcd_dram_pkg.sv
`timescale 1ns/1ps
package lcd_dram_pkg;
   localparam int LCD_COLS      = 132;  // segment columns
   localparam int LCD_PAGES     = 8;    // full-height data pages
   localparam int LCD_BYTE_W    = 8;    // host data width = rows per page
endpackage

// File: rtl/lcd_dram_addr.sv
`timescale 1ns/1ps
module lcd_dram_addr #(
   parameter int NUM_COLS = 132,
   parameter int COL_W    = 8,
   parameter int PAGE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_page,
   input  logic [PAGE_W-1:0] page_in,
   input  logic              set_col,
   input  logic [COL_W-1:0]  col_in,
   input  logic              access,
   output logic [PAGE_W-1:0] page_q,
   output logic [COL_W-1:0]  col_q
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

   generate
      if (NUM_COLS < 2 || NUM_COLS > (1 << COL_W)) begin : g_bad_cols
         $error("lcd_dram_addr: NUM_COLS does not fit COL_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         col_q  <= '0;
      end else begin
         if (set_page)
            page_q <= page_in;
         if (set_col)
            col_q <= (col_in > LAST_COL) ? LAST_COL : col_in;
         else if (access && col_q != LAST_COL)
            col_q <= col_q + COL_W'(1);
      end
   end

   AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= LAST_COL); // R4
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !set_col && col_q != LAST_COL) |=> (col_q == $past(col_q) + COL_W'(1))); // R3
   AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !set_col && col_q == LAST_COL) |=> (col_q == LAST_COL)); // R4
   AST_COL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (set_col && col_in > LAST_COL) |=> (col_q == LAST_COL)); // R6
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !set_page |=> $stable(page_q)); // R5
endmodule

// File: rtl/lcd_dram_store.sv
`timescale 1ns/1ps
module lcd_dram_store #(
   parameter int NUM_COLS  = 132,
   parameter int NUM_PAGES = 8,
   parameter int DATA_W    = 8,
   parameter int COL_W     = 8,
   parameter int PAGE_W    = 4,
   parameter int ROW_W     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] page,
   input  logic [COL_W-1:0]  col,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ROW_W-1:0]  scan_row,
   output logic [NUM_COLS-1:0] scan_bits
);
   localparam int IDX_W    = $clog2(DATA_W);
   localparam int NUM_ROWS = NUM_PAGES * DATA_W + 1;  // data pages + indicator row

   generate
      if (ROW_W != PAGE_W + IDX_W) begin : g_bad_row_w
         $error("lcd_dram_store: ROW_W must equal PAGE_W + log2(DATA_W)");
      end
   endgenerate

   // One vector per common row: a scan read is a single array read.
   logic [NUM_COLS-1:0] mem [NUM_ROWS];
   logic [DATA_W-1:0]   rd_byte;

   always_ff @(posedge clk) begin
      if (wr) begin
         for (int i = 0; i < DATA_W; i++) begin
            if (int'({page, IDX_W'(i)}) < NUM_ROWS)
               mem[{page, IDX_W'(i)}][col] <= wdata[i];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         rd_byte[i] = (int'({page, IDX_W'(i)}) < NUM_ROWS) ? mem[{page, IDX_W'(i)}][col] : 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata     <= '0;
         scan_bits <= '0;
      end else begin
         if (rd)
            rdata <= rd_byte;
         scan_bits <= (int'(scan_row) < NUM_ROWS) ? mem[scan_row] : '0;
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata)); // R9
endmodule

// File: rtl/lcd_dram_seg_map.sv
`timescale 1ns/1ps
module lcd_dram_seg_map #(
   parameter int WIDTH     = 132,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic [WIDTH-1:0] row_bits,
   input  logic             reverse,
   output logic [WIDTH-1:0] seg_bits
);
   generate
      if (MIRROR_EN) begin : g_mirror
         for (genvar s = 0; s < WIDTH; s++) begin : g_seg
            assign seg_bits[s] = reverse ? row_bits[WIDTH-1-s] : row_bits[s];
         end
      end else begin : g_straight
         logic unused_reverse;
         assign unused_reverse = reverse;
         assign seg_bits = row_bits;
      end
   endgenerate
endmodule

// File: rtl/lcd_dram_ctrl.sv
`timescale 1ns/1ps
module lcd_dram_ctrl
   import lcd_dram_pkg::*;
#(
   parameter int NUM_COLS  = LCD_COLS,
   parameter int NUM_PAGES = LCD_PAGES,
   parameter int DATA_W    = LCD_BYTE_W,
   parameter bit MIRROR_EN = 1'b1,
   localparam int COL_W    = $clog2(NUM_COLS),
   localparam int PAGE_W   = $clog2(NUM_PAGES) + 1,
   localparam int ROW_W    = PAGE_W + $clog2(DATA_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_page,
   input  logic [PAGE_W-1:0]   page_in,
   input  logic                set_col,
   input  logic [COL_W-1:0]    col_in,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   input  logic [ROW_W-1:0]    scan_row,
   input  logic                seg_reverse,
   output logic [NUM_COLS-1:0] scan_seg
);
   generate
      if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 2) begin : g_bad_data_w
         $error("lcd_dram_ctrl: DATA_W must be a power of two");
      end
      if ((NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("lcd_dram_ctrl: NUM_PAGES must be a power of two");
      end
   endgenerate

   logic [PAGE_W-1:0]   page_q;
   logic [COL_W-1:0]    col_q;
   logic [NUM_COLS-1:0] row_bits;
   logic                reverse_q;

   lcd_dram_addr #(
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W),
      .PAGE_W   (PAGE_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_page (set_page),
      .page_in  (page_in),
      .set_col  (set_col),
      .col_in   (col_in),
      .access   (host_wr | host_rd),
      .page_q   (page_q),
      .col_q    (col_q)
   );

   lcd_dram_store #(
      .NUM_COLS  (NUM_COLS),
      .NUM_PAGES (NUM_PAGES),
      .DATA_W    (DATA_W),
      .COL_W     (COL_W),
      .PAGE_W    (PAGE_W),
      .ROW_W     (ROW_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .page      (page_q),
      .col       (col_q),
      .wr        (host_wr),
      .rd        (host_rd),
      .wdata     (host_wdata),
      .rdata     (host_rdata),
      .scan_row  (scan_row),
      .scan_bits (row_bits)
   );

   // Direction is sampled with the row so both take effect on the same edge.
   always_ff @(posedge clk) begin
      if (!rst_n)
         reverse_q <= 1'b0;
      else
         reverse_q <= seg_reverse;
   end

   lcd_dram_seg_map #(
      .WIDTH     (NUM_COLS),
      .MIRROR_EN (MIRROR_EN)
   ) u_seg_map (
      .row_bits  (row_bits),
      .reverse   (reverse_q),
      .seg_bits  (scan_seg)
   );

   AST_VOID_PAGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && page_q > PAGE_W'(NUM_PAGES)) |=> (host_rdata == '0)); // R8
   AST_INDICATOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && page_q == PAGE_W'(NUM_PAGES)) |=> (host_rdata[DATA_W-1:1] == '0)); // R7
endmodule

// File: tb/lcd_dram_ctrl_test.sv
`timescale 1ns/1ps
module lcd_dram_ctrl_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         set_page = 1'b0;
   logic [3:0]   page_in = '0;
   logic         set_col = 1'b0;
   logic [7:0]   col_in = '0;
   logic         host_wr = 1'b0;
   logic         host_rd = 1'b0;
   logic [7:0]   host_wdata = '0;
   logic [7:0]   host_rdata;
   logic [6:0]   scan_row = '0;
   logic         seg_reverse = 1'b0;
   logic [131:0] scan_seg;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lcd_dram_ctrl uut (
      .clk (clk), .rst_n (rst_n),
      .set_page (set_page), .page_in (page_in),
      .set_col (set_col), .col_in (col_in),
      .host_wr (host_wr), .host_rd (host_rd),
      .host_wdata (host_wdata), .host_rdata (host_rdata),
      .scan_row (scan_row), .seg_reverse (seg_reverse),
      .scan_seg (scan_seg)
   );

   // {page, column, data}
   localparam logic [19:0] VEC [9] = '{
      {4'd0,  8'd0,   8'hA5},
      {4'd3,  8'd10,  8'h3C},
      {4'd7,  8'd131, 8'h81},
      {4'd1,  8'd20,  8'h99},
      {4'd9,  8'd20,  8'h77},
      {4'd8,  8'd5,   8'hFF},
      {4'd15, 8'd0,   8'h12},
      {4'd2,  8'd200, 8'h5A},
      {4'd3,  8'd121, 8'h00}
   };

   function automatic logic [7:0] exp_byte(logic [3:0] p, logic [7:0] d);
      if (p < 4'd8)       return d;
      else if (p == 4'd8) return {7'b0, d[0]};
      else                return 8'h00;
   endfunction

   task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk1(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic do_page(logic [3:0] p);
      @(negedge clk); set_page = 1'b1; page_in = p;
      @(negedge clk); set_page = 1'b0;
   endtask

   task automatic do_col(logic [7:0] c);
      @(negedge clk); set_col = 1'b1; col_in = c;
      @(negedge clk); set_col = 1'b0;
   endtask

   task automatic do_wr(logic [7:0] d);
      @(negedge clk); host_wr = 1'b1; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic do_rd(string tag, logic [7:0] exp);
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
      chk8(tag, host_rdata, exp);
   endtask

   task automatic do_scan(logic [6:0] r, logic rev);
      @(negedge clk); scan_row = r; seg_reverse = rev;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      string tag;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk8("R1 rdata at reset", host_rdata, 8'h00);
      chk1("R1 scan_seg at reset", scan_seg == '0, 1'b1);
      rst_n = 1'b1;
      do_wr(8'h11);
      do_col(8'd0);
      do_rd("R1 first write lands on page 0 col 0", 8'h11);

      // vector table: write all, then read all back
      foreach (VEC[k]) begin
         do_page(VEC[k][19:16]);
         do_col(VEC[k][15:8]);
         do_wr(VEC[k][7:0]);
      end
      foreach (VEC[k]) begin
         if (VEC[k][15:8] > 8'd131)      tag = "R6 clamped column readback";
         else if (VEC[k][19:16] == 4'd8) tag = "R7 indicator page readback";
         else if (VEC[k][19:16] > 4'd8)  tag = "R8 void page readback";
         else                            tag = "R2 data page readback";
         do_page(VEC[k][19:16]);
         do_col(VEC[k][15:8]);
         do_rd(tag, exp_byte(VEC[k][19:16], VEC[k][7:0]));
      end
      // R8: page 9 col 20 write did not alias onto page 1 col 20
      do_page(4'd1); do_col(8'd20);
      do_rd("R8 page 1 unchanged by page 9 write", 8'h99);

      // R3: auto increment
      do_page(4'd4); do_col(8'd50);
      do_wr(8'h01); do_wr(8'h02); do_wr(8'h03);
      do_col(8'd50);
      do_rd("R3 increment byte 0", 8'h01);
      do_rd("R3 increment byte 1", 8'h02);
      do_rd("R3 increment byte 2", 8'h03);

      // R4 / R5: saturation, no page carry
      do_page(4'd5); do_col(8'd0); do_wr(8'h00);
      do_page(4'd4); do_col(8'd130);
      do_wr(8'hAA); do_wr(8'hBB); do_wr(8'hCC);
      do_col(8'd130);
      do_rd("R4 column 130", 8'hAA);
      do_rd("R4 column 131 last write", 8'hCC);
      do_rd("R4 column 131 held", 8'hCC);
      do_page(4'd5); do_col(8'd0);
      do_rd("R5 next page untouched", 8'h00);

      // R9: read latency one edge
      do_page(4'd3); do_col(8'd10);
      @(negedge clk); host_rd = 1'b1;
      chk8("R9 rdata before edge", host_rdata, 8'h00);
      @(negedge clk); host_rd = 1'b0;
      chk8("R9 rdata after one edge", host_rdata, 8'h3C);
      @(negedge clk);
      chk8("R9 rdata held", host_rdata, 8'h3C);

      // R2: bit-to-row mapping via the scan port (page 3 col 10 = 3C)
      do_scan(7'd24, 1'b0); chk1("R2 row 24 seg 10", scan_seg[10], 1'b0);
      do_scan(7'd26, 1'b0); chk1("R2 row 26 seg 10", scan_seg[10], 1'b1);
      chk1("R2 row 26 seg 121", scan_seg[121], 1'b0);
      do_scan(7'd29, 1'b0); chk1("R2 row 29 seg 10", scan_seg[10], 1'b1);
      do_scan(7'd31, 1'b0); chk1("R2 row 31 seg 10", scan_seg[10], 1'b0);
      do_scan(7'd0, 1'b0);  chk1("R2 row 0 seg 0", scan_seg[0], 1'b1);
      do_scan(7'd7, 1'b0);  chk1("R2 row 7 seg 0", scan_seg[0], 1'b1);
      do_scan(7'd1, 1'b0);  chk1("R2 row 1 seg 0", scan_seg[0], 1'b0);
      // R7: indicator row
      do_scan(7'd64, 1'b0); chk1("R7 indicator row seg 5", scan_seg[5], 1'b1);
      // R10: mirrored segment order
      do_scan(7'd26, 1'b1);
      chk1("R10 reversed seg 121", scan_seg[121], 1'b1);
      chk1("R10 reversed seg 10", scan_seg[10], 1'b0);
      do_scan(7'd56, 1'b1); chk1("R10 reversed seg 0 = col 131", scan_seg[0], 1'b1);
      do_scan(7'd56, 1'b0); chk1("R10 straight seg 131", scan_seg[131], 1'b1);

      // R11: scan and host write to the same row on one edge
      do_page(4'd6); do_col(8'd7); do_wr(8'hFF);
      do_col(8'd7);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = 8'h00; scan_row = 7'd48; seg_reverse = 1'b0;
      @(negedge clk); host_wr = 1'b0;
      chk1("R11 scan sees old data", scan_seg[7], 1'b1);
      @(negedge clk);
      chk1("R11 scan sees new data next", scan_seg[7], 1'b0);
      do_col(8'd7);
      do_rd("R2 overwritten byte", 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule